// File: doc/BRIEF.md
# ACPI Event Interrupt Generator

This block keeps the power-management event state of a platform controller: a 16-bit event status register, a 16-bit event enable register and a 16-bit power control register. Four event sources feed it with single-cycle pulses: the periodic timer wrap, the global-lock release, the power button and the real-time-clock alarm. Each pulse latches a sticky status bit. Software clears a status bit by writing one to it.

From the stored state the block drives a level-sensitive interrupt request. The request stays high while any of the four source bits is both pending and enabled. The block also drives an arm signal for the timer-wrap logic outside it. That signal is high only when the timer source is enabled and its status bit is clear, so no new wrap is armed while one is still waiting for service.

Software reaches the registers through a port that moves one byte per access. Writes take effect on the clock edge. Reads return data combinationally for the byte that is addressed.

Top module: `acpi_evt_irq`

## Requirements
- R1: After reset, all three registers read 0x0000, `intReq` is low and `tmrArm` is low.
- R2: A pulse on `evTmrOvf`, `evGlbLock`, `evPwrBtn` or `evRtc` sets status bit 0, 5, 8 or 10 respectively, visible from the next clock edge.
- R3: Writing a status byte clears each status bit written as one. Bits written as zero keep their value.
- R4: If an event pulse and a write-one-to-clear of the same status bit fall in the same cycle, the bit stays set.
- R5: `intReq` is high exactly when, for at least one of bits 0, 5, 8 and 10, both the status bit and the enable bit are set.
- R6: The enable and control registers are plain read/write registers. A write to one byte leaves the other byte unchanged.
- R7: `tmrArm` equals enable bit 0 AND NOT status bit 0.
- R8: The control register has no effect on `intReq` or `tmrArm`.
- R9: Byte addresses: 0/1 status low/high, 2/3 enable low/high, 4/5 control low/high. Addresses 6 and 7 read 0x00, and writes to them change nothing.
- R10: `intReq` falls on the clock edge of the clear write or enable write that removes its last cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Byte write strobe |
| regAddr | input | 3 | Byte address |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr (combinational) |
| evTmrOvf | input | 1 | Timer-wrap event pulse |
| evGlbLock | input | 1 | Global-lock release event pulse |
| evPwrBtn | input | 1 | Power-button event pulse |
| evRtc | input | 1 | RTC alarm event pulse |
| intReq | output | 1 | Level interrupt request |
| tmrArm | output | 1 | Timer-wrap arming enable |

## Verification
Every register changes on the edge where its write strobe or event pulse is sampled. `intReq`, `tmrArm` and the read data are combinational from those registers, so each result is due one edge after its stimulus. The bench drives every stimulus on a falling edge and holds it across exactly one rising edge. It checks at the following falling edge, with the read address settled for a short delay first. The collision case and the case that removes the last cause are therefore observed in the first cycle after the edge.

// File: rtl/acpi_evt_pkg.sv
package acpi_evt_pkg;
  localparam int REG_W   = 16;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 3;
  localparam int BIT_TMR = 0;
  localparam int BIT_GLB = 5;
  localparam int BIT_PWR = 8;
  localparam int BIT_RTC = 10;
  localparam logic [REG_W-1:0] SRC_MASK =
    (REG_W'(1) << BIT_TMR) | (REG_W'(1) << BIT_GLB) |
    (REG_W'(1) << BIT_PWR) | (REG_W'(1) << BIT_RTC);
  localparam logic [ADDR_W-1:0] A_STS_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_STS_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_EN_LO  = 3'd2;
  localparam logic [ADDR_W-1:0] A_EN_HI  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTL_LO = 3'd4;
  localparam logic [ADDR_W-1:0] A_CTL_HI = 3'd5;

  typedef struct packed {
    logic wrStsLo;
    logic wrStsHi;
    logic wrEnLo;
    logic wrEnHi;
    logic wrCtlLo;
    logic wrCtlHi;
  } wr_strobe_t;
endpackage

// File: rtl/acpi_evt_ctrl.sv
module acpi_evt_ctrl
  import acpi_evt_pkg::*;
(
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output wr_strobe_t        strobes
);
  always_comb begin
    strobes = '0;
    if (regWrEn) begin
      unique case (regAddr)
        A_STS_LO: strobes.wrStsLo = 1'b1;
        A_STS_HI: strobes.wrStsHi = 1'b1;
        A_EN_LO:  strobes.wrEnLo  = 1'b1;
        A_EN_HI:  strobes.wrEnHi  = 1'b1;
        A_CTL_LO: strobes.wrCtlLo = 1'b1;
        A_CTL_HI: strobes.wrCtlHi = 1'b1;
        default:  strobes = '0;
      endcase
    end
  end
endmodule

// File: rtl/acpi_evt_dp.sv
module acpi_evt_dp
  import acpi_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  wr_strobe_t        strobes,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              evTmrOvf,
  input  logic              evGlbLock,
  input  logic              evPwrBtn,
  input  logic              evRtc,
  output logic [BYTE_W-1:0] rdData,
  output logic              intReq,
  output logic              tmrArm
);
  logic [REG_W-1:0] stsQ, enQ, ctlQ;
  logic [REG_W-1:0] setVec, clrVec;

  always_comb begin
    setVec = '0;
    setVec[BIT_TMR] = evTmrOvf;
    setVec[BIT_GLB] = evGlbLock;
    setVec[BIT_PWR] = evPwrBtn;
    setVec[BIT_RTC] = evRtc;
    clrVec = '0;
    if (strobes.wrStsLo) clrVec[BYTE_W-1:0]     = wrData;
    if (strobes.wrStsHi) clrVec[REG_W-1:BYTE_W] = wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stsQ <= '0;
      enQ  <= '0;
      ctlQ <= '0;
    end else begin
      stsQ <= (stsQ & ~clrVec) | setVec;
      if (strobes.wrEnLo)  enQ[BYTE_W-1:0]      <= wrData;
      if (strobes.wrEnHi)  enQ[REG_W-1:BYTE_W]  <= wrData;
      if (strobes.wrCtlLo) ctlQ[BYTE_W-1:0]     <= wrData;
      if (strobes.wrCtlHi) ctlQ[REG_W-1:BYTE_W] <= wrData;
    end
  end

  assign intReq = |(stsQ & enQ & SRC_MASK);
  assign tmrArm = enQ[BIT_TMR] & ~stsQ[BIT_TMR];

  always_comb begin
    unique case (rdAddr)
      A_STS_LO: rdData = stsQ[BYTE_W-1:0];
      A_STS_HI: rdData = stsQ[REG_W-1:BYTE_W];
      A_EN_LO:  rdData = enQ[BYTE_W-1:0];
      A_EN_HI:  rdData = enQ[REG_W-1:BYTE_W];
      A_CTL_LO: rdData = ctlQ[BYTE_W-1:0];
      A_CTL_HI: rdData = ctlQ[REG_W-1:BYTE_W];
      default:  rdData = '0;
    endcase
  end

  // R4: a pulse wins over a same-cycle clear
  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    evRtc |=> stsQ[BIT_RTC]);
  // R2: the global-lock pulse latches
  a_r2_glb_latch: assert property (@(posedge clk) disable iff (!rstN)
    evGlbLock |=> stsQ[BIT_GLB]);
  // R3: writing a zero keeps a pending bit
  a_r3_zero_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrStsHi && !wrData[BIT_PWR-BYTE_W] && stsQ[BIT_PWR]) |=> stsQ[BIT_PWR]);
  // R6: a low-byte enable write leaves the high byte alone
  a_r6_lane_isolated: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrEnLo && !strobes.wrEnHi) |=> enQ[REG_W-1:BYTE_W] == $past(enQ[REG_W-1:BYTE_W]));
endmodule

// File: rtl/acpi_evt_irq.sv
module acpi_evt_irq
  import acpi_evt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       evTmrOvf,
  input  logic       evGlbLock,
  input  logic       evPwrBtn,
  input  logic       evRtc,
  output logic       intReq,
  output logic       tmrArm
);
  wr_strobe_t strobes;

  acpi_evt_ctrl uCtrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobes (strobes)
  );

  acpi_evt_dp uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrData    (regWrData),
    .rdAddr    (regAddr),
    .evTmrOvf  (evTmrOvf),
    .evGlbLock (evGlbLock),
    .evPwrBtn  (evPwrBtn),
    .evRtc     (evRtc),
    .rdData    (regRdData),
    .intReq    (intReq),
    .tmrArm    (tmrArm)
  );

  // R7: once a timer wrap is pending, arming is off
  a_r7_no_rearm: assert property (@(posedge clk) disable iff (!rstN)
    evTmrOvf |=> !tmrArm);
endmodule

// File: tb/tb_acpi_evt_irq.sv
`timescale 1ns/1ps
module tb_acpi_evt_irq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic evTmrOvf = 0, evGlbLock = 0, evPwrBtn = 0, evRtc = 0;
  logic intReq, tmrArm;
  int nRun = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  acpi_evt_irq dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .evTmrOvf(evTmrOvf),
    .evGlbLock(evGlbLock), .evPwrBtn(evPwrBtn), .evRtc(evRtc),
    .intReq(intReq), .tmrArm(tmrArm)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rd16(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    regAddr = a; #1 v[7:0] = regRdData;
    regAddr = a + 3'd1; #1 v[15:8] = regRdData;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: evTmrOvf = 1;
      1: evGlbLock = 1;
      2: evPwrBtn = 1;
      default: evRtc = 1;
    endcase
    @(negedge clk);
    evTmrOvf = 0; evGlbLock = 0; evPwrBtn = 0; evRtc = 0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd16(3'd0, v); check("R1 status", v, 16'h0);
    rd16(3'd2, v); check("R1 enable", v, 16'h0);
    rd16(3'd4, v); check("R1 control", v, 16'h0);
    check("R1 intReq", {15'b0, intReq}, 16'h0);
    check("R1 tmrArm", {15'b0, tmrArm}, 16'h0);
  endtask

  task automatic t_events();
    logic [15:0] v;
    pulse(0); rd16(3'd0, v); check("R2 timer bit0", v, 16'h0001);
    pulse(1); rd16(3'd0, v); check("R2 glb bit5", v, 16'h0021);
    pulse(2); rd16(3'd0, v); check("R2 pwr bit8", v, 16'h0121);
    pulse(3); rd16(3'd0, v); check("R2 rtc bit10", v, 16'h0521);
    check("R5 no irq with enable zero", {15'b0, intReq}, 16'h0);
  endtask

  task automatic t_clear();
    logic [15:0] v;
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    rd16(3'd0, v); check("R3 zero write keeps", v, 16'h0521);
    wr(3'd0, 8'h20);
    rd16(3'd0, v); check("R3 clear glb", v, 16'h0501);
    wr(3'd1, 8'h05); wr(3'd0, 8'h01);
    rd16(3'd0, v); check("R3 clear all", v, 16'h0000);
  endtask

  task automatic t_collide();
    logic [15:0] v;
    @(negedge clk);
    evRtc = 1; regWrEn = 1; regAddr = 3'd1; regWrData = 8'h04;
    @(negedge clk);
    evRtc = 0; regWrEn = 0;
    rd16(3'd0, v); check("R4 event beats clear", v, 16'h0400);
    wr(3'd1, 8'h04);
    rd16(3'd0, v); check("R4 later clear works", v, 16'h0000);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    wr(3'd2, 8'hDE); wr(3'd3, 8'hFA);
    rd16(3'd2, v); check("R6 enable rw", v, 16'hFADE);
    check("R5 enable without status", {15'b0, intReq}, 16'h0);
    wr(3'd2, 8'h21);
    rd16(3'd2, v); check("R6 lane isolation", v, 16'hFA21);
    wr(3'd3, 8'h00);
    pulse(2);
    check("R5 pwr pending but disabled", {15'b0, intReq}, 16'h0);
    wr(3'd3, 8'h01);
    #1 check("R5 enable raises irq", {15'b0, intReq}, 16'h1);
    wr(3'd3, 8'h00);
    #1 check("R10 enable clear drops irq", {15'b0, intReq}, 16'h0);
    wr(3'd1, 8'h01);
    pulse(1);
    check("R5 glb raises irq", {15'b0, intReq}, 16'h1);
    wr(3'd0, 8'h20);
    #1 check("R10 clear drops irq", {15'b0, intReq}, 16'h0);
  endtask

  task automatic t_timer();
    check("R7 arm when enabled idle", {15'b0, tmrArm}, 16'h1);
    pulse(0);
    check("R7 arm off when pending", {15'b0, tmrArm}, 16'h0);
    check("R5 timer irq", {15'b0, intReq}, 16'h1);
    wr(3'd0, 8'h01);
    #1 check("R7 arm back after clear", {15'b0, tmrArm}, 16'h1);
    check("R10 irq low after clear", {15'b0, intReq}, 16'h0);
  endtask

  task automatic t_ctrl_unmapped();
    logic [15:0] v;
    wr(3'd4, 8'hA5); wr(3'd5, 8'h3C);
    rd16(3'd4, v); check("R6 control rw", v, 16'h3CA5);
    check("R8 control no irq", {15'b0, intReq}, 16'h0);
    check("R8 control keeps arm", {15'b0, tmrArm}, 16'h1);
    wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
    rd16(3'd6, v); check("R9 unmapped read zero", v, 16'h0);
    rd16(3'd0, v); check("R9 status unchanged", v, 16'h0);
    rd16(3'd2, v); check("R9 enable unchanged", v, 16'h0021);
    rd16(3'd4, v); check("R9 control unchanged", v, 16'h3CA5);
  endtask

  initial begin
    #2_000_000;
    nRun++; nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset();
    t_events();
    t_clear();
    t_collide();
    t_irq();
    t_timer();
    t_ctrl_unmapped();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule